// File: doc/BRIEF.md
# Radix-4 Delay-Feedback Butterfly Stage

This block is one stage of a single-path delay-feedback pipeline FFT or IFFT. It takes one complex sample per clock and gives one complex sample per clock. The stream is cut into blocks of 4·D samples. The first three quarters of a block are parked in three feedback delay lines, each D words deep. While the last quarter arrives, every cycle brings together one parked sample from each line and the new sample in a four-point butterfly. The butterfly uses adders only. One of its four results goes straight out, and the other three go back into the delay lines. Those three are then released one quarter at a time while the next block is being parked. A chain of such stages, with D falling by a factor of four from stage to stage and a twiddle multiplier between stages, forms a full transform.

A 2-bit phase, taken from the top of a counter of valid samples, selects which line is filled and which line is drained. A frame-start flag resets the counter. An inverse flag swaps the signs of the ±j terms for the backward transform. The `SCALE` parameter picks the precision policy. With `SCALE` = 0 the results grow by two bits and are exact. With `SCALE` = 1 every result is shifted right arithmetically by two and keeps the input width.

Top module: `r4sdf_stage`

## Requirements
- R1: While reset is active and after it is released, before any valid input, `out_valid` is 0 and both output parts are 0.
- R2: Valid samples are counted from the sample that carries `in_start`, which is index 0. The phase of a sample is floor(index / D) mod 4. D must be a power of two. Cycles with `in_valid` low do not advance the count.
- R3: A valid sample with frame index s produces an output with `out_valid` high on the edge that captures it, if s ≥ 3·D. If s < 3·D there is no output. The first result of a frame therefore appears 3·D edges after its first sample is captured.
- R4: Let a, b, c and d be the samples at indices 4DB+i, 4DB+D+i, 4DB+2D+i and 4DB+3D+i. The forward outputs are X0 = a+b+c+d, X1 = (a−c) − j(b−d), X2 = a−b+c−d and X3 = (a−c) + j(b−d). X0 leaves at frame index 4DB+3D+i. X1, X2 and X3 leave at indices 4D(B+1)+i, +D+i and +2D+i.
- R5: When `inverse` is 1 on the sample at index 4DB+3D+i, that butterfly uses +j in X1 and −j in X3. At all other indices `inverse` has no effect.
- R6: A cycle with `in_valid` low leaves the stored state unchanged. It drives `out_valid` to 0 on the next edge and holds both output parts.
- R7: `in_start` may arrive in the middle of a block. It restarts the count at 0, and the next output comes only at frame index 3·D.
- R8: With `SCALE` = 0 the outputs are W+2 bits wide and exact for all inputs, including full-scale inputs of either sign.
- R9: With `SCALE` = 1 the outputs are W bits wide and equal floor(X/4) for each exact result X.
- R10: With D = 1 each delay line is a single register and the phase moves on with every valid sample. R3 to R9 still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_start | input | 1 | This valid sample is frame index 0 |
| inverse | input | 1 | 1 selects the backward transform for the butterfly in this cycle |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample present |
| out_re | output | W+2, or W when SCALE=1 | Output real part |
| out_im | output | W+2, or W when SCALE=1 | Output imaginary part |

## Verification
Each result is due exactly one edge after the valid input sample whose frame index is 3·D or more. From that index the bench also derives the block, the butterfly output and the lane. Before driving a new sample, the bench checks the outputs against the sample it drove in the previous cycle. It expects `out_valid` high only when that sample was valid and late enough in the frame, and it compares the data against butterfly sums it computes itself. The same stimulus drives a D = 4 unscaled instance and a D = 1 scaled instance. The stimulus covers dense frames, idle-cycle bubbles, full-scale values, per-cycle changes of the inverse flag and a restart in mid-block. At the end of each frame the bench checks the number of outputs against the count of samples at index 3·D or above.

// File: rtl/r4sdf_stage.sv
module r4sdf_stage #(
  parameter int D     = 16,
  parameter int W     = 12,
  parameter int SCALE = 0
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          in_valid,
  input  logic                                          in_start,
  input  logic                                          inverse,
  input  logic signed [W-1:0]                           in_re,
  input  logic signed [W-1:0]                           in_im,
  output logic                                          out_valid,
  output logic signed [((SCALE != 0) ? W : W + 2)-1:0]  out_re,
  output logic signed [((SCALE != 0) ? W : W + 2)-1:0]  out_im
);
  localparam int OW = (SCALE != 0) ? W : W + 2;
  localparam int SW = OW + 2;
  localparam int CW = $clog2(4 * D);

  logic [CW-1:0] cnt, cur;
  logic [1:0]    mode;
  logic          primed, live;

  assign cur  = in_start ? '0 : cnt;
  assign mode = cur[CW-1 -: 2];
  assign live = primed & ~in_start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else if (in_valid) begin
      cnt    <= cur + 1'b1;
      primed <= live | (mode == 2'd3);
    end

  logic signed [OW-1:0] hd_re [3];
  logic signed [OW-1:0] hd_im [3];
  logic signed [OW-1:0] y_re  [4];
  logic signed [OW-1:0] y_im  [4];
  logic signed [OW-1:0] wr_re [3];
  logic signed [OW-1:0] wr_im [3];

  function automatic logic signed [OW-1:0] fit(input logic signed [SW-1:0] v);
    if (SCALE != 0) fit = v[OW+1:2];
    else            fit = v[OW-1:0];
  endfunction

  always_comb begin
    logic signed [SW-1:0] ar, ai, br, bi, cr, ci, dr, di, ur, ui, vr, vi;
    ar = SW'(hd_re[0]);  ai = SW'(hd_im[0]);
    br = SW'(hd_re[1]);  bi = SW'(hd_im[1]);
    cr = SW'(hd_re[2]);  ci = SW'(hd_im[2]);
    dr = SW'(in_re);     di = SW'(in_im);
    ur = ar - cr;        ui = ai - ci;
    vr = br - dr;        vi = bi - di;
    y_re[0] = fit(ar + br + cr + dr);
    y_im[0] = fit(ai + bi + ci + di);
    y_re[2] = fit(ar - br + cr - dr);
    y_im[2] = fit(ai - bi + ci - di);
    if (!inverse) begin
      y_re[1] = fit(ur + vi);  y_im[1] = fit(ui - vr);
      y_re[3] = fit(ur - vi);  y_im[3] = fit(ui + vr);
    end else begin
      y_re[1] = fit(ur - vi);  y_im[1] = fit(ui + vr);
      y_re[3] = fit(ur + vi);  y_im[3] = fit(ui - vr);
    end
  end

  for (genvar m = 0; m < 3; m++) begin : g_line
    logic signed [OW-1:0] sr_re [D];
    logic signed [OW-1:0] sr_im [D];
    wire shift_en = in_valid && (mode == 2'(m) || mode == 2'd3);

    assign wr_re[m] = (mode == 2'd3) ? y_re[m+1] : OW'(in_re);
    assign wr_im[m] = (mode == 2'd3) ? y_im[m+1] : OW'(in_im);

    always_ff @(posedge clk)
      if (shift_en) begin
        sr_re[0] <= wr_re[m];
        sr_im[0] <= wr_im[m];
        for (int k = 1; k < D; k++) begin
          sr_re[k] <= sr_re[k-1];
          sr_im[k] <= sr_im[k-1];
        end
      end

    assign hd_re[m] = sr_re[D-1];
    assign hd_im[m] = sr_im[D-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid && (live || mode == 2'd3);
      if (in_valid) begin
        out_re <= (mode == 2'd3) ? y_re[0] : hd_re[mode];
        out_im <= (mode == 2'd3) ? y_im[0] : hd_im[mode];
      end
    end
endmodule

// File: rtl/r4sdf_stage_chk.sv
module r4sdf_stage_chk #(
  parameter int D     = 16,
  parameter int W     = 12,
  parameter int SCALE = 0
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          in_valid,
  input logic                                          in_start,
  input logic                                          out_valid,
  input logic signed [((SCALE != 0) ? W : W + 2)-1:0]  out_re,
  input logic signed [((SCALE != 0) ? W : W + 2)-1:0]  out_im,
  input logic [$clog2(4 * D)-1:0]                      cnt
);
  localparam int CW = $clog2(4 * D);

  a_r6_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_re) && $stable(out_im)));

  a_r7_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> !out_valid);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_start && cnt == CW'(4 * D - 1)) |=> (cnt == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt));

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> (cnt == CW'(1)));
endmodule

bind r4sdf_stage r4sdf_stage_chk #(.D(D), .W(W), .SCALE(SCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .cnt(cnt)
);

// File: tb/r4sdf_stage_tb.sv
module r4sdf_stage_tb;
  localparam int W  = 8;
  localparam int DA = 4;
  localparam int DB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, inverse = 1'b0;
  logic signed [W-1:0] in_re = '0, in_im = '0;
  logic a_v, b_v;
  logic signed [W+1:0] a_re, a_im;
  logic signed [W-1:0] b_re, b_im;

  always #2.5 clk = ~clk;

  r4sdf_stage #(.D(DA), .W(W), .SCALE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .inverse(inverse), .in_re(in_re), .in_im(in_im),
    .out_valid(a_v), .out_re(a_re), .out_im(a_im));

  r4sdf_stage #(.D(DB), .W(W), .SCALE(1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .inverse(inverse), .in_re(in_re), .in_im(in_im),
    .out_valid(b_v), .out_re(b_re), .out_im(b_im));

  int total = 0, bad = 0;
  int nout_a, nout_b;
  bit done = 0;
  int din_re [0:255];
  int din_im [0:255];
  bit dinv   [0:255];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model(input int dd, input int sc, input int idx, output int er, output int ei);
    int k, bl, q, i, base, ar, ai, br, bi, cr, ci, dr, di, ur, ui, vr, vi;
    bit iv;
    k = idx - 3 * dd;  bl = k / (4 * dd);  q = (k / dd) % 4;  i = k % dd;
    base = bl * 4 * dd;
    ar = din_re[base + i];          ai = din_im[base + i];
    br = din_re[base + dd + i];     bi = din_im[base + dd + i];
    cr = din_re[base + 2*dd + i];   ci = din_im[base + 2*dd + i];
    dr = din_re[base + 3*dd + i];   di = din_im[base + 3*dd + i];
    iv = dinv[base + 3*dd + i];
    ur = ar - cr; ui = ai - ci; vr = br - dr; vi = bi - di;
    case (q)
      0: begin er = ar + br + cr + dr; ei = ai + bi + ci + di; end
      2: begin er = ar - br + cr - dr; ei = ai - bi + ci - di; end
      1: if (!iv) begin er = ur + vi; ei = ui - vr; end
         else     begin er = ur - vi; ei = ui + vr; end
      default: if (!iv) begin er = ur - vi; ei = ui + vr; end
               else     begin er = ur + vi; ei = ui - vr; end
    endcase
    if (sc != 0) begin er = er >>> 2; ei = ei >>> 2; end
  endtask

  // Output for the sample driven last cycle (pv, pidx) is checked here.
  task automatic check_out(input bit pv, input int pidx);
    int er, ei;
    bit ea, eb;
    ea = pv && pidx >= 3 * DA;
    eb = pv && pidx >= 3 * DB;
    chk("R3 valid D=4", int'(a_v), int'(ea));
    chk("R10 valid D=1", int'(b_v), int'(eb));
    if (ea && a_v) begin
      nout_a++;
      model(DA, 0, pidx, er, ei);
      chk("R4/R5/R8 re D=4", int'(a_re), er);
      chk("R4/R5/R8 im D=4", int'(a_im), ei);
    end
    if (eb && b_v) begin
      nout_b++;
      model(DB, 1, pidx, er, ei);
      chk("R9/R10 re D=1", int'(b_re), er);
      chk("R9/R10 im D=1", int'(b_im), ei);
    end
  endtask

  // kind: 0 random forward, 1 full-scale, 2 random with bubbles and inverse toggling
  task automatic run_frame(input int n, input int kind, input bit inv);
    int idx = 0, pidx = 0;
    bit pv = 0, v;
    nout_a = 0; nout_b = 0;
    while (idx < n) begin
      @(negedge clk);
      check_out(pv, pidx);
      lfsr = step(lfsr);
      v = (kind == 2 && idx != 0) ? lfsr[3] : 1'b1;
      in_valid = v;
      in_start = v && idx == 0;
      if (v) begin
        if (kind == 1) begin
          din_re[idx] = ((idx / 2) % 2 == 0) ? -128 : 127;
          din_im[idx] = (idx % 3 == 0) ? 127 : -128;
        end else begin
          din_re[idx] = int'($signed(lfsr[7:0]));
          lfsr = step(lfsr);
          din_im[idx] = int'($signed(lfsr[7:0]));
        end
        dinv[idx] = (kind == 2) ? lfsr[5] : inv;
        in_re = W'(din_re[idx]);
        in_im = W'(din_im[idx]);
        inverse = dinv[idx];
        pidx = idx;
        idx++;
      end else begin
        in_re = W'(lfsr[11:4]);
        inverse = lfsr[9];
      end
      pv = v;
    end
    @(negedge clk);
    check_out(pv, pidx);
    in_valid = 0; in_start = 0;
    @(negedge clk);
    check_out(1'b0, 0);
    chk("R3 count D=4", nout_a, (n > 3 * DA) ? n - 3 * DA : 0);
    chk("R10 count D=1", nout_b, (n > 3 * DB) ? n - 3 * DB : 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset valid", int'(a_v) + int'(b_v), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle valid", int'(a_v) + int'(b_v), 0);
    chk("R1 idle data", int'(a_re) + int'(a_im) + int'(b_re) + int'(b_im), 0);
    run_frame(64, 0, 1'b0);   // R4 forward, dense
    run_frame(64, 0, 1'b1);   // R5 inverse
    run_frame(48, 1, 1'b1);   // R8 full-scale
    run_frame(48, 1, 1'b0);   // R8 full-scale forward
    run_frame(70, 2, 1'b0);   // R6 bubbles, R5 per-sample inverse
    run_frame(30, 0, 1'b0);   // cut mid-block
    run_frame(40, 0, 1'b0);   // R7 restart after a mid-block cut
    run_frame(10, 0, 1'b0);   // R3 frame shorter than 3D+1
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule